// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Receiver with Sleep and Wakeup

This block turns an asynchronous serial line back into data words. A shared baud divisor supplies a strobe at sixteen times the bit rate. The receiver finds the falling edge of a start bit and takes three samples near the middle of every bit. It settles each bit by majority and builds a word of 8 or 9 bits, sent least significant bit first. It checks the stop level and, when enabled, the parity. It also watches the line for a full character time of ones, which is an idle character.

Received words leave through a valid/ready port. `out_valid` rises when a word lands and stays high, with the word and its error flags held, until a cycle in which `out_ready` is also high. No further back-pressure is possible: the line cannot be paused. A frame that completes while a word is still waiting is dropped, and the overrun flag is raised. On a multi-drop bus the receiver can be put to sleep. While asleep it reports nothing. It wakes either on an idle line or on a frame whose top data bit is 1. The receive line can come from the receive pin, from the local transmitter's serial output, or from the shared transmit pin in single-wire mode.

Top module: `serial_rx_wake`

## Requirements
- R1: A frame is a 0 start bit, then a field of 8 bits (`nine_bits`=0) or 9 bits (`nine_bits`=1) sent LSB first, then a stop bit. The field appears right-aligned on `out_data`, and bit 8 reads 0 in 8-bit mode. A bit lasts 16 strobes of `baud_tick`, whatever the strobe spacing.
- R2: Each bit is resolved by a majority vote of samples taken at strobes 7, 8 and 9 of the bit. If any of the three samples in any bit of a frame disagree, `flag_noise` is set with that frame.
- R3: A start bit whose vote reads 1 is dropped, and the receiver searches for a start edge again without delivering anything.
- R4: `flag_frame` is set with a word whose stop bit votes 0.
- R5: With `parity_en`=1 the top field bit is the parity bit and stays in the word. `flag_parity` is set when the number of ones in the field is odd while `parity_odd`=0, or even while `parity_odd`=1.
- R6: `out_valid` holds until a cycle with `out_ready`=1. That handshake clears `out_valid`, `flag_overrun`, `flag_noise`, `flag_frame` and `flag_parity`. If a frame completes in the same cycle as the handshake, the new word loads with no overrun.
- R7: If a frame completes while `out_valid`=1 and no handshake occurs in that cycle, `flag_overrun` is set. The held word and its noise, frame and parity flags are kept, so `flag_noise` is never raised by the overrun frame.
- R8: A pulse on `sleep_req` sets `rx_sleep`. While asleep, no word, flag or idle indication is produced. With `wake_on_addr`=0 an idle character clears `rx_sleep` and leaves `flag_idle` at 0.
- R9: With `wake_on_addr`=1 a frame whose top field bit (bit 7 in 8-bit mode, bit 8 in 9-bit mode) is 1 clears `rx_sleep` and is delivered. Other frames are discarded while asleep.
- R10: `flag_idle` is set after (field length + 2) x 16 strobes of continuous ones. With `idle_after_stop`=0 the ones are counted from any 1 inside a frame. With `idle_after_stop`=1 counting starts only after the stop bit has been resolved. The flag is set once per stretch of line activity and is cleared by the next start edge.
- R11: `rx_active` rises on a start edge and falls when an idle character is detected.
- R12: With `loop_en`=0 the receiver listens to `rxd_pin`. With `loop_en`=1 and `loop_from_pin`=0 it listens to `tx_loop_bit`. With `loop_en`=1 and `loop_from_pin`=1 it listens to `txd_pin_in`. `txd_drive_en` is 1 except in that last mode, where it equals `tx_pin_out_dir`.
- R13: `irq_rx` equals `rx_irq_en` AND (`out_valid` OR `flag_overrun`). `irq_idle` equals `idle_irq_en` AND `flag_idle`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | Strobe at 16x the bit rate |
| rx_en | input | 1 | Receiver enable |
| nine_bits | input | 1 | Field length: 0 = 8 bits, 1 = 9 bits |
| parity_en | input | 1 | Top field bit is parity |
| parity_odd | input | 1 | 0 = even parity, 1 = odd parity |
| wake_on_addr | input | 1 | Wake source: 0 = idle line, 1 = address mark |
| idle_after_stop | input | 1 | Idle count starts after the stop bit |
| loop_en | input | 1 | Take the line from an internal source |
| loop_from_pin | input | 1 | In loop mode, use the transmit pin (single wire) |
| tx_pin_out_dir | input | 1 | Single-wire direction of the transmit pin |
| rx_irq_en | input | 1 | Enables the data and overrun request |
| idle_irq_en | input | 1 | Enables the idle request |
| sleep_req | input | 1 | Pulse that puts the receiver to sleep |
| rxd_pin | input | 1 | Receive pin |
| tx_loop_bit | input | 1 | Serial output of the local transmitter |
| txd_pin_in | input | 1 | Level read back from the transmit pin |
| txd_drive_en | output | 1 | The transmit pin may be driven |
| out_data | output | 9 | Received field |
| out_valid | output | 1 | Word available |
| out_ready | input | 1 | Consumer accepts the word |
| flag_overrun | output | 1 | A word was lost |
| flag_noise | output | 1 | Sample disagreement in the held word |
| flag_frame | output | 1 | Stop bit read 0 |
| flag_parity | output | 1 | Parity mismatch |
| flag_idle | output | 1 | Idle character seen |
| rx_active | output | 1 | Reception in progress |
| rx_sleep | output | 1 | Receiver asleep |
| irq_rx | output | 1 | Data or overrun request |
| irq_idle | output | 1 | Idle request |

## Verification
Two events can fall in the same clock cycle: the consumer's handshake on the output port and the completion of the next frame. A word is left pending, and the handshake is then moved one cycle at a time across the whole stop bit of a second frame. The bench does not predict which cycle is the crossover. Instead, each trial must be consistent. If overrun was visible at the handshake, the second word is gone afterwards. If not, the second word is waiting with no overrun. Across the sweep both outcomes must occur, and the handshake must always return the first word.

// File: rtl/rx_pkg.sv
package rx_pkg;
  typedef enum logic [1:0] {
    ST_SEARCH = 2'd0,
    ST_START  = 2'd1,
    ST_DATA   = 2'd2,
    ST_STOP   = 2'd3
  } rx_state_e;
endpackage

// File: rtl/rx_src_mux.sv
module rx_src_mux #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic loop_en,
  input  logic loop_from_pin,
  input  logic tx_pin_out_dir,
  input  logic rxd_pin,
  input  logic tx_loop_bit,
  input  logic txd_pin_in,
  output logic line_s,
  output logic txd_drive_en
);
  logic                   raw;
  logic [SYNC_STAGES-1:0] sync_q;

  always_comb begin
    if (!loop_en)          raw = rxd_pin;
    else if (loop_from_pin) raw = txd_pin_in;
    else                   raw = tx_loop_bit;
    txd_drive_en = !(loop_en && loop_from_pin) || tx_pin_out_dir;
  end

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_q <= '1;
        else        sync_q <= raw;
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], raw};
    end
  endgenerate

  assign line_s = sync_q[SYNC_STAGES-1];
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
  import rx_pkg::*;
#(
  parameter int OSR    = 16,
  parameter int WORD_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              tick,
  input  logic              line,
  input  logic              nine_bits,
  input  logic              parity_en,
  input  logic              parity_odd,
  output logic              done,
  output logic [WORD_W-1:0] word,
  output logic              fe,
  output logic              nf,
  output logic              pf,
  output logic              msb,
  output logic              start_seen,
  output logic              searching
);
  localparam int CW = $clog2(OSR);
  localparam int BW = $clog2(WORD_W + 1);
  localparam logic [CW-1:0] SMP_A = CW'(OSR / 2 - 1);
  localparam logic [CW-1:0] SMP_B = CW'(OSR / 2);
  localparam logic [CW-1:0] SMP_C = CW'(OSR / 2 + 1);
  localparam logic [CW-1:0] LAST  = CW'(OSR - 1);

  rx_state_e         state;
  logic [CW-1:0]     cnt;
  logic [BW-1:0]     bidx;
  logic [WORD_W-1:0] shreg;
  logic              s_a, s_b, noise_acc;
  logic              vote, disagree;
  logic [BW-1:0]     last_bit;
  logic [WORD_W-1:0] aligned;

  always_comb begin
    vote      = (s_a & s_b) | (s_a & line) | (s_b & line);
    disagree  = !((s_a == s_b) && (s_b == line));
    last_bit  = nine_bits ? BW'(WORD_W - 1) : BW'(WORD_W - 2);
    aligned   = nine_bits ? shreg : {1'b0, shreg[WORD_W-1:1]};
    searching = (state == ST_SEARCH);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_SEARCH; cnt <= '0; bidx <= '0; shreg <= '0;
      s_a <= 1'b1; s_b <= 1'b1; noise_acc <= 1'b0;
      done <= 1'b0; word <= '0; fe <= 1'b0; nf <= 1'b0; pf <= 1'b0;
      msb <= 1'b0; start_seen <= 1'b0;
    end else begin
      done       <= 1'b0;
      start_seen <= 1'b0;
      if (!en) begin
        state <= ST_SEARCH;
        cnt   <= '0;
      end else if (tick) begin
        if (state == ST_SEARCH) begin
          if (!line) begin
            state      <= ST_START;
            cnt        <= CW'(1);
            start_seen <= 1'b1;
            noise_acc  <= 1'b0;
          end
        end else begin
          cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
          if (cnt == SMP_A) s_a <= line;
          if (cnt == SMP_B) s_b <= line;
          if (cnt == SMP_C) begin
            case (state)
              ST_START: if (vote) state <= ST_SEARCH;
                        else noise_acc <= disagree;
              ST_DATA: begin
                shreg     <= {vote, shreg[WORD_W-1:1]};
                noise_acc <= noise_acc | disagree;
              end
              ST_STOP: begin
                done  <= 1'b1;
                fe    <= !vote;
                nf    <= noise_acc | disagree;
                word  <= aligned;
                pf    <= parity_en & ((^aligned) ^ parity_odd);
                msb   <= nine_bits ? aligned[WORD_W-1] : aligned[WORD_W-2];
                state <= ST_SEARCH;
              end
              default: ;
            endcase
          end
          if (cnt == LAST) begin
            case (state)
              ST_START: begin state <= ST_DATA; bidx <= '0; end
              ST_DATA: begin
                if (bidx == last_bit) state <= ST_STOP;
                else                  bidx  <= bidx + 1'b1;
              end
              default: ;
            endcase
          end
        end
      end
    end
  end

  AST_DONE_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(state) == ST_STOP)); // R1
  AST_FALSE_START_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tick && state == ST_START && cnt == SMP_C && vote) |=> (state == ST_SEARCH && !done)); // R3
endmodule

// File: rtl/rx_idle_det.sv
module rx_idle_det #(
  parameter int OSR    = 16,
  parameter int WORD_W = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic tick,
  input  logic line,
  input  logic after_stop,
  input  logic searching,
  input  logic start_seen,
  input  logic nine_bits,
  output logic idle_evt,
  output logic active
);
  localparam int TW = $clog2((WORD_W + 2) * OSR + 1);
  localparam logic [TW-1:0] LONG_T  = TW'((WORD_W + 2) * OSR);
  localparam logic [TW-1:0] SHORT_T = TW'((WORD_W + 1) * OSR);

  logic [TW-1:0] run_cnt;
  logic [TW-1:0] thresh;
  logic          count_ok;

  always_comb begin
    thresh   = nine_bits ? LONG_T : SHORT_T;
    count_ok = after_stop ? searching : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt <= '0; idle_evt <= 1'b0; active <= 1'b0;
    end else begin
      idle_evt <= 1'b0;
      if (!en) begin
        run_cnt <= '0;
        active  <= 1'b0;
      end else begin
        if (start_seen) active <= 1'b1;
        if (tick) begin
          if (!line || !count_ok) run_cnt <= '0;
          else if (run_cnt != thresh) run_cnt <= run_cnt + 1'b1;
          if (line && count_ok && run_cnt == thresh - 1'b1 && active) begin
            idle_evt <= 1'b1;
            active   <= 1'b0;
          end
        end
      end
    end
  end

  AST_IDLE_ON_HIGH_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    idle_evt |-> $past(line)); // R10
  AST_RAF_DROPS_ON_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_evt && !start_seen) |-> !active); // R11
endmodule

// File: rtl/serial_rx_wake.sv
module serial_rx_wake #(
  parameter int OSR         = 16,
  parameter int WORD_W      = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              rx_en,
  input  logic              nine_bits,
  input  logic              parity_en,
  input  logic              parity_odd,
  input  logic              wake_on_addr,
  input  logic              idle_after_stop,
  input  logic              loop_en,
  input  logic              loop_from_pin,
  input  logic              tx_pin_out_dir,
  input  logic              rx_irq_en,
  input  logic              idle_irq_en,
  input  logic              sleep_req,
  input  logic              rxd_pin,
  input  logic              tx_loop_bit,
  input  logic              txd_pin_in,
  output logic              txd_drive_en,
  output logic [WORD_W-1:0] out_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              flag_overrun,
  output logic              flag_noise,
  output logic              flag_frame,
  output logic              flag_parity,
  output logic              flag_idle,
  output logic              rx_active,
  output logic              rx_sleep,
  output logic              irq_rx,
  output logic              irq_idle
);
  logic              line_s, done, fe_n, nf_n, pf_n, msb_n, start_seen, searching, idle_evt;
  logic [WORD_W-1:0] word_n;
  logic              pop, addr_hit, accept, idle_wake;

  rx_src_mux #(.SYNC_STAGES(SYNC_STAGES)) u_mux (
    .clk(clk), .rst_n(rst_n), .loop_en(loop_en), .loop_from_pin(loop_from_pin),
    .tx_pin_out_dir(tx_pin_out_dir), .rxd_pin(rxd_pin), .tx_loop_bit(tx_loop_bit),
    .txd_pin_in(txd_pin_in), .line_s(line_s), .txd_drive_en(txd_drive_en));

  rx_frame_fsm #(.OSR(OSR), .WORD_W(WORD_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .en(rx_en), .tick(baud_tick), .line(line_s),
    .nine_bits(nine_bits), .parity_en(parity_en), .parity_odd(parity_odd),
    .done(done), .word(word_n), .fe(fe_n), .nf(nf_n), .pf(pf_n), .msb(msb_n),
    .start_seen(start_seen), .searching(searching));

  rx_idle_det #(.OSR(OSR), .WORD_W(WORD_W)) u_idle (
    .clk(clk), .rst_n(rst_n), .en(rx_en), .tick(baud_tick), .line(line_s),
    .after_stop(idle_after_stop), .searching(searching), .start_seen(start_seen),
    .nine_bits(nine_bits), .idle_evt(idle_evt), .active(rx_active));

  always_comb begin
    pop       = out_valid && out_ready;
    addr_hit  = done && wake_on_addr && msb_n;
    idle_wake = idle_evt && !wake_on_addr;
    accept    = done && (!rx_sleep || addr_hit);
    irq_rx    = rx_irq_en && (out_valid || flag_overrun);
    irq_idle  = idle_irq_en && flag_idle;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_data <= '0; out_valid <= 1'b0; flag_overrun <= 1'b0; flag_noise <= 1'b0;
      flag_frame <= 1'b0; flag_parity <= 1'b0; flag_idle <= 1'b0; rx_sleep <= 1'b0;
    end else begin
      if (accept && out_valid && !pop) begin
        flag_overrun <= 1'b1;
      end else if (accept) begin
        out_valid    <= 1'b1;
        out_data     <= word_n;
        flag_noise   <= nf_n;
        flag_frame   <= fe_n;
        flag_parity  <= pf_n;
        flag_overrun <= 1'b0;
      end else if (pop) begin
        out_valid    <= 1'b0;
        flag_overrun <= 1'b0;
        flag_noise   <= 1'b0;
        flag_frame   <= 1'b0;
        flag_parity  <= 1'b0;
      end
      if (start_seen)                   flag_idle <= 1'b0;
      else if (idle_evt && !rx_sleep)   flag_idle <= 1'b1;
      if (sleep_req)                              rx_sleep <= 1'b1;
      else if (rx_sleep && (idle_wake || addr_hit)) rx_sleep <= 1'b0;
    end
  end

  AST_OVR_HOLDS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && out_valid && !out_ready) |=> ($stable(out_data) && flag_overrun)); // R7
  AST_NF_KEPT_ON_OVR: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && out_valid && !out_ready) |=> $stable(flag_noise)); // R7
  AST_POP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !accept) |=> (!out_valid && !flag_overrun && !flag_frame)); // R6
  AST_SLEEP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_sleep && !addr_hit) |=> (!$rose(out_valid) && !$rose(flag_idle))); // R8
endmodule

// File: tb/serial_rx_wake_tb.sv
module serial_rx_wake_tb;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0, baud_tick = 1'b0, rx_en = 1'b1;
  logic nine_bits = 1'b0, parity_en = 1'b0, parity_odd = 1'b0, wake_on_addr = 1'b0;
  logic idle_after_stop = 1'b0, loop_en = 1'b0, loop_from_pin = 1'b0, tx_pin_out_dir = 1'b0;
  logic rx_irq_en = 1'b0, idle_irq_en = 1'b0, sleep_req = 1'b0, out_ready = 1'b0;
  logic line_val = 1'b1, rxd_force = 1'b1;
  int   path = 0;
  logic rxd_pin, tx_loop_bit, txd_pin_in, txd_drive_en;
  logic [8:0] out_data;
  logic out_valid, flag_overrun, flag_noise, flag_frame, flag_parity, flag_idle;
  logic rx_active, rx_sleep, irq_rx, irq_idle;

  assign rxd_pin     = (path == 0) ? line_val : rxd_force;
  assign tx_loop_bit = (path == 1) ? line_val : 1'b1;
  assign txd_pin_in  = (path == 2) ? line_val : 1'b1;

  serial_rx_wake u_dut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .rx_en(rx_en), .nine_bits(nine_bits),
    .parity_en(parity_en), .parity_odd(parity_odd), .wake_on_addr(wake_on_addr),
    .idle_after_stop(idle_after_stop), .loop_en(loop_en), .loop_from_pin(loop_from_pin),
    .tx_pin_out_dir(tx_pin_out_dir), .rx_irq_en(rx_irq_en), .idle_irq_en(idle_irq_en),
    .sleep_req(sleep_req), .rxd_pin(rxd_pin), .tx_loop_bit(tx_loop_bit),
    .txd_pin_in(txd_pin_in), .txd_drive_en(txd_drive_en), .out_data(out_data),
    .out_valid(out_valid), .out_ready(out_ready), .flag_overrun(flag_overrun),
    .flag_noise(flag_noise), .flag_frame(flag_frame), .flag_parity(flag_parity),
    .flag_idle(flag_idle), .rx_active(rx_active), .rx_sleep(rx_sleep),
    .irq_rx(irq_rx), .irq_idle(irq_idle));

  int tdiv = 1, tcnt = 0, total = 0, bad = 0, cyc = 0;
  always @(negedge clk) begin
    if (tcnt >= tdiv - 1) begin tcnt <= 0; baud_tick <= 1'b1; end
    else begin tcnt <= tcnt + 1; baud_tick <= 1'b0; end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      bad = bad + 1;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  logic       pop_ovr, pop_val;
  logic [8:0] pop_dat;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // glitch: 0 none, 1 flip at clock 8 of bit, 2 flip at clocks 7 and 8
  task automatic send_bit(input logic b, input int pop_at, input int glitch);
    for (int i = 0; i < 16 * tdiv; i++) begin
      line_val = b;
      if ((glitch == 1 && i == 8 * tdiv) || (glitch == 2 && i >= 7 * tdiv && i < 9 * tdiv))
        line_val = !b;
      if (i == pop_at) begin
        pop_ovr = flag_overrun; pop_val = out_valid; pop_dat = out_data; out_ready = 1'b1;
      end else out_ready = 1'b0;
      @(negedge clk);
    end
    out_ready = 1'b0;
    line_val  = 1'b1;
  endtask

  task automatic send(input logic [8:0] f, input int nb, input logic stop,
                      input int pop_at, input int gbit, input int glen);
    send_bit(1'b0, -1, 0);
    for (int i = 0; i < nb; i++) send_bit(f[i], -1, (i == gbit) ? glen : 0);
    send_bit(stop, pop_at, 0);
    if (!stop) send_bit(1'b1, -1, 0);
  endtask

  task automatic pop();
    out_ready = 1'b1; @(negedge clk); out_ready = 1'b0;
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  logic [8:0] f;
  logic       par;
  bit         seen_ovr, seen_new;

  initial begin
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(2);
    // reset state
    chk("R6 reset valid", out_valid, 0);
    chk("R7 reset overrun", flag_overrun, 0);
    chk("R8 reset sleep", rx_sleep, 0);
    chk("R11 reset active", rx_active, 0);
    chk("R12 reset drive enable", txd_drive_en, 1);

    // R1: every byte in 8-bit mode
    for (int b = 0; b < 256; b++) begin
      send(9'(b), 8, 1'b1, -1, -1, 0);
      chk("R1 byte sweep", {out_valid, flag_noise, flag_frame, flag_parity, out_data},
          {4'b1000, 9'(b)});
      pop();
    end
    // R1: wider strobe spacing
    tdiv = 2; wait_clk(4);
    send(9'h0A5, 8, 1'b1, -1, -1, 0);
    chk("R1 strobe every 2 clocks", {out_valid, out_data}, {1'b1, 9'h0A5});
    pop();
    tdiv = 1; wait_clk(4);
    // R1: 9-bit field without parity
    nine_bits = 1'b1;
    send(9'h1C3, 9, 1'b1, -1, -1, 0);
    chk("R1 nine bit field", {out_valid, flag_parity, out_data}, {2'b10, 9'h1C3});
    pop();
    // R5: parity sweep
    parity_en = 1'b1;
    for (int v = 0; v < 256; v += 9)
      for (int od = 0; od < 2; od++)
        for (int fl = 0; fl < 2; fl++) begin
          parity_odd = od[0];
          par = (^v[7:0]) ^ od[0] ^ fl[0];
          f = {par, v[7:0]};
          send(f, 9, 1'b1, -1, -1, 0);
          chk("R5 parity sweep", {out_valid, flag_parity, out_data}, {1'b1, fl[0], f});
          pop();
        end
    parity_en = 1'b0; parity_odd = 1'b0; nine_bits = 1'b0;

    // R2: single-sample glitch keeps the bit, raises noise
    send(9'h0F0, 8, 1'b1, -1, 2, 1);
    chk("R2 one sample off", {out_valid, flag_noise, out_data}, {2'b11, 9'h0F0});
    pop();
    chk("R6 noise cleared by handshake", {out_valid, flag_noise}, 0);
    // R2: two samples off flip the majority
    send(9'h0F0, 8, 1'b1, -1, 5, 2);
    chk("R2 majority flips bit", {flag_noise, out_data}, {1'b1, 9'h0D0});
    pop();

    // R3: short low pulse is not a start bit
    line_val = 1'b0; wait_clk(4); line_val = 1'b1; wait_clk(40);
    chk("R3 false start gives nothing", out_valid, 0);
    send(9'h03C, 8, 1'b1, -1, -1, 0);
    chk("R3 next frame after false start", {out_valid, out_data}, {1'b1, 9'h03C});
    pop();

    // R4: stop bit low
    send(9'h05A, 8, 1'b0, -1, -1, 0);
    chk("R4 framing error", {out_valid, flag_frame, out_data}, {2'b11, 9'h05A});
    pop();
    chk("R6 handshake clears frame error", {out_valid, flag_frame}, 0);

    // R7 / R13: overrun keeps the word; noise of the lost frame not shown
    rx_irq_en = 1'b0;
    send(9'h011, 8, 1'b1, -1, -1, 0);
    chk("R13 rx request masked", irq_rx, 0);
    rx_irq_en = 1'b1; wait_clk(1);
    chk("R13 rx request on data", irq_rx, 1);
    send(9'h0EE, 8, 1'b0, -1, 3, 1);
    chk("R7 overrun keeps word", {out_valid, flag_overrun, out_data}, {2'b11, 9'h011});
    chk("R7 no noise or frame flag from lost frame", {flag_noise, flag_frame}, 0);
    pop();
    chk("R6 handshake clears overrun", {out_valid, flag_overrun, irq_rx}, 0);
    rx_irq_en = 1'b0;

    // R6: handshake swept across completion of a second frame
    seen_ovr = 0; seen_new = 0;
    for (int k = 2; k < 16; k++) begin
      send(9'h03C, 8, 1'b1, -1, -1, 0);
      send(9'h0C3, 8, 1'b1, k, -1, 0);
      chk("R6 handshake returns first word", {pop_val, pop_dat}, {1'b1, 9'h03C});
      if (pop_ovr) begin
        seen_ovr = 1;
        chk("R7 late handshake loses second word", {out_valid, flag_overrun}, 0);
      end else begin
        seen_new = 1;
        chk("R6 early or same-cycle handshake keeps second word",
            {out_valid, flag_overrun, out_data}, {2'b10, 9'h0C3});
        pop();
      end
    end
    chk("R6 both outcomes seen in sweep", {seen_ovr, seen_new}, 2'b11);

    // R10 / R11: idle counting points
    wait_clk(250);
    chk("R11 inactive after quiet line", rx_active, 0);
    idle_irq_en = 1'b1;
    send(9'h080, 8, 1'b1, -1, -1, 0);
    chk("R11 active after start", rx_active, 1);
    wait_clk(120);
    chk("R10 no idle yet, counted from frame", flag_idle, 0);
    wait_clk(20);
    chk("R10 idle counted from last data bit", {flag_idle, irq_idle}, 2'b11);
    chk("R11 idle clears active", rx_active, 0);
    pop();
    idle_after_stop = 1'b1;
    send(9'h080, 8, 1'b1, -1, -1, 0);
    wait_clk(140);
    chk("R10 idle after stop not yet", flag_idle, 0);
    wait_clk(30);
    chk("R10 idle after stop set", flag_idle, 1);
    idle_irq_en = 1'b0; wait_clk(1);
    chk("R13 idle request masked", irq_idle, 0);
    pop();
    send(9'h044, 8, 1'b1, -1, -1, 0);
    chk("R10 start edge clears idle", {flag_idle, out_data}, {1'b0, 9'h044});
    pop();
    idle_after_stop = 1'b0;
    wait_clk(250);

    // R8: sleep, idle-line wake
    sleep_req = 1'b1; wait_clk(1); sleep_req = 1'b0;
    chk("R8 sleep set", rx_sleep, 1);
    send(9'h055, 8, 1'b1, -1, -1, 0);
    chk("R8 nothing while asleep", {out_valid, rx_sleep}, 2'b01);
    wait_clk(200);
    chk("R8 idle wakes without idle flag", {rx_sleep, flag_idle}, 0);
    send(9'h066, 8, 1'b1, -1, -1, 0);
    chk("R8 receives after wake", {out_valid, out_data}, {1'b1, 9'h066});
    pop();

    // R9: address-mark wake
    wake_on_addr = 1'b1;
    sleep_req = 1'b1; wait_clk(1); sleep_req = 1'b0;
    send(9'h012, 8, 1'b1, -1, -1, 0);
    wait_clk(200);
    chk("R9 plain frame and idle ignored", {out_valid, rx_sleep, flag_idle}, 3'b010);
    send(9'h092, 8, 1'b1, -1, -1, 0);
    chk("R9 address frame wakes and delivers", {out_valid, rx_sleep, out_data}, {2'b10, 9'h092});
    pop();
    wake_on_addr = 1'b0;

    // R12: source selection
    loop_en = 1'b1; path = 1; wait_clk(4); rxd_force = 1'b0;
    chk("R12 drive enable in internal loop", txd_drive_en, 1);
    send(9'h0B7, 8, 1'b1, -1, -1, 0);
    chk("R12 internal loop source", {out_valid, out_data}, {1'b1, 9'h0B7});
    pop();
    loop_from_pin = 1'b1; path = 2; wait_clk(4);
    chk("R12 single wire input direction", txd_drive_en, 0);
    tx_pin_out_dir = 1'b1; wait_clk(1);
    chk("R12 single wire output direction", txd_drive_en, 1);
    send(9'h04D, 8, 1'b1, -1, -1, 0);
    chk("R12 single wire source", {out_valid, out_data}, {1'b1, 9'h04D});
    pop();
    rxd_force = 1'b1; wait_clk(4);
    loop_en = 1'b0; loop_from_pin = 1'b0; path = 0; wait_clk(4);
    send(9'h021, 8, 1'b1, -1, -1, 0);
    chk("R12 back to receive pin", {out_valid, out_data}, {1'b1, 9'h021});
    pop();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule